// File: doc/BRIEF.md
# Huge Page TLB Entry Splitter

This block takes one page-table entry from a hardware page walker and turns it into one half of an even/odd TLB entry pair. It also reports the page-size exponent of that half. A walker that reaches a huge-page mapping has already marked the entry in two ways: a huge marker, and the directory level at which the walk stopped. This block removes those walk-private markers. It moves the huge-global flag onto the ordinary global bit. It then computes the exponent of half the huge page from the base and width of the recorded level. For the odd half, it steps the physical address up by one half-page.

The walker supplies four index-field descriptors. Each one is a base (the lowest virtual-address bit of an index) and a width (the number of bits in that index). Slot 0 describes the leaf page table and slots 1 to 3 describe the directory levels. Entries without the huge marker pass through with only the address masking applied. The logic is combinational with one registered output stage, so a result appears one cycle after it is presented, and a new entry can be accepted every cycle.

Top module: `huge_tlb_splitter`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Synchronous reset drives `out_valid`, `out_entry` and `out_ps` to zero.
- R2: Before any other processing, every `in_entry` bit at position `PA_W` (default 48) or above is cleared. The even-half and non-huge outputs therefore never have those bits set.
- R3: Bit 6 of the masked entry is the huge marker. When it is 0, `out_entry` equals the masked entry, `in_odd` has no effect, and `out_ps` equals slot-0 base + slot-0 width − 1.
- R4: For a huge entry, the even-half output has the level field (bits 14:13) cleared and the huge-global bit (bit 12) cleared. All bits below `PA_W` other than 6, 12, 13 and 14 keep their input values.
- R5: For a huge entry, output bit 6 (the global bit) equals input bit 12 (the huge-global flag). The huge marker itself is therefore dropped.
- R6: The 2-bit level field (bits 14:13) of a huge entry selects descriptor slot k = level. Slot k occupies `cfg_base[k*BW +: BW]` and `cfg_width[k*WW +: WW]`. Level 0 selects the leaf slot 0.
- R7: For a huge entry, `out_ps` = selected base + selected width − 1, taken modulo 2^`PS_W`.
- R8: For a huge entry with `in_odd` high, `out_entry` is the rewritten entry plus 2^`out_ps`, as a 64-bit sum. The addend is zero when `out_ps` ≥ 64. With `in_odd` low, no addend is applied.
- R9: While `in_valid` is low, `out_entry` and `out_ps` keep their previous values.
- R10: Entries presented on consecutive cycles each produce their own result on the following cycle, with no gap or mixing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry on `in_entry` is to be converted |
| in_entry | input | 64 | Page-table entry from the walker |
| in_odd | input | 1 | 1 selects the odd half of the pair, 0 the even half |
| cfg_base | input | 4*BW | Index base per slot; slot 0 = leaf, slots 1..3 = directory levels |
| cfg_width | input | 4*WW | Index width per slot, same slot order |
| out_valid | output | 1 | Registered result valid |
| out_entry | output | 64 | Rewritten TLB half entry |
| out_ps | output | max(BW,WW)+1 | Page-size exponent of this half |

## Verification
The bench drives each of the four level values and gives every slot a distinct descriptor. A design that indexes the descriptors wrongly, or that uses the leaf slot for every huge entry, therefore shows a wrong exponent at once. It checks both values of the huge-global flag, which exposes a design that leaves the marker in bit 6 or that forgets to clear bit 12.

Odd-half cases cover three situations:
- an addend that carries past bit `PA_W − 1`, which catches a design that masks after the add;
- an exponent of 64 or more, which must add nothing;
- a non-huge entry with `in_odd` high, which must not be offset.

Idle cycles and back-to-back entries expose a stage that does not hold its output or that loses or mixes up successive results.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int ENTRY_W    = 64;
  localparam int HUGE_BIT   = 6;   // huge marker on input
  localparam int GLOBAL_BIT = 6;   // global bit on output
  localparam int HGLB_BIT   = 12;  // huge-global flag on input
  localparam int LVL_LO     = 13;  // level field low bit
  localparam int LVL_W      = 2;
  localparam int NUM_SLOT   = 1 << LVL_W;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [LVL_W-1:0]   lvl_t;
endpackage

// File: rtl/hts_decode.sv
module hts_decode
  import hts_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  entry_t raw,
  output entry_t masked,
  output logic   huge,
  output logic   hglb,
  output lvl_t   lvl
);
  localparam entry_t PA_MASK = (PA_W >= ENTRY_W) ? {ENTRY_W{1'b1}}
                                                 : ((entry_t'(1) << PA_W) - entry_t'(1));

  always_comb begin
    masked = raw & PA_MASK;
    huge   = masked[HUGE_BIT];
    hglb   = masked[HGLB_BIT];
    lvl    = masked[LVL_LO +: LVL_W];
  end
endmodule

// File: rtl/hts_size_sel.sv
module hts_size_sel
  import hts_pkg::*;
#(
  parameter int BW  = 6,
  parameter int WW  = 6,
  parameter int PSW = 7
) (
  input  logic [NUM_SLOT*BW-1:0] cfg_base,
  input  logic [NUM_SLOT*WW-1:0] cfg_width,
  input  logic                   huge,
  input  lvl_t                   lvl,
  output logic [PSW-1:0]         ps
);
  logic [PSW-1:0] slot_sum [NUM_SLOT];

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    assign slot_sum[k] = PSW'(cfg_base[k*BW +: BW]) + PSW'(cfg_width[k*WW +: WW])
                         - PSW'(1);
  end

  always_comb begin
    if (huge) ps = slot_sum[lvl];
    else      ps = slot_sum[0];
  end
endmodule

// File: rtl/hts_rewrite.sv
module hts_rewrite
  import hts_pkg::*;
#(
  parameter int PSW = 7
) (
  input  entry_t         masked,
  input  logic           huge,
  input  logic           hglb,
  input  logic           odd,
  input  logic [PSW-1:0] ps,
  output entry_t         entry
);
  localparam bit WIDE = (PSW > 6);

  entry_t rw;
  entry_t step;

  always_comb begin
    rw = masked;
    if (huge) begin
      rw[LVL_LO +: LVL_W] = '0;
      rw[HGLB_BIT]        = 1'b0;
      rw[GLOBAL_BIT]      = hglb;
    end
    if (WIDE && (ps >= PSW'(ENTRY_W))) step = '0;
    else                               step = entry_t'(1) << ps;
    entry = (huge && odd) ? (rw + step) : rw;
  end
endmodule

// File: rtl/huge_tlb_splitter.sv
module huge_tlb_splitter
  import hts_pkg::*;
#(
  parameter int PA_W = 48,
  parameter int BW   = 6,
  parameter int WW   = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [63:0]                       in_entry,
  input  logic                              in_odd,
  input  logic [4*BW-1:0]                   cfg_base,
  input  logic [4*WW-1:0]                   cfg_width,
  output logic                              out_valid,
  output logic [63:0]                       out_entry,
  output logic [((BW > WW) ? BW : WW):0]    out_ps
);
  localparam int PSW = ((BW > WW) ? BW : WW) + 1;

  entry_t         masked_c, entry_c;
  logic           huge_c, hglb_c;
  lvl_t           lvl_c;
  logic [PSW-1:0] ps_c;

  hts_decode #(.PA_W(PA_W)) u_dec (
    .raw(in_entry), .masked(masked_c), .huge(huge_c), .hglb(hglb_c), .lvl(lvl_c)
  );

  hts_size_sel #(.BW(BW), .WW(WW), .PSW(PSW)) u_size (
    .cfg_base(cfg_base), .cfg_width(cfg_width), .huge(huge_c), .lvl(lvl_c), .ps(ps_c)
  );

  hts_rewrite #(.PSW(PSW)) u_rw (
    .masked(masked_c), .huge(huge_c), .hglb(hglb_c), .odd(in_odd), .ps(ps_c),
    .entry(entry_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_entry <= '0;
      out_ps    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_entry <= entry_c;
        out_ps    <= ps_c;
      end
    end
  end
endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
  parameter int PA_W = 48,
  parameter int PSW  = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [63:0]    in_entry,
  input logic           in_odd,
  input logic           out_valid,
  input logic [63:0]    out_entry,
  input logic [PSW-1:0] out_ps
);
  localparam logic [63:0] LOW_MASK = (PA_W >= 64) ? {64{1'b1}}
                                                  : ((64'd1 << PA_W) - 64'd1);

  // R1
  a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  a_r2_upper_clear: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_odd |=> (out_entry & ~LOW_MASK) == 64'd0);

  // R3
  a_r3_plain_pass: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_entry[6] |=> out_entry == ($past(in_entry) & LOW_MASK));

  // R4
  a_r4_markers_cleared: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_entry[6] && !in_odd |=> out_entry[14:13] == 2'b00 && !out_entry[12]);

  // R5
  a_r5_global_moved: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_entry[6] && !in_odd |=> out_entry[6] == $past(in_entry[12]));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_entry) && $stable(out_ps));
endmodule

bind huge_tlb_splitter hts_checker #(.PA_W(PA_W), .PSW(PSW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_entry(in_entry), .in_odd(in_odd),
  .out_valid(out_valid), .out_entry(out_entry), .out_ps(out_ps)
);

// File: tb/huge_tlb_splitter_tb.sv
`timescale 1ns/1ps
module huge_tlb_splitter_tb;
  localparam int PA_W = 48;
  localparam int BW   = 6;
  localparam int WW   = 6;
  localparam int PSW  = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [63:0]     in_entry = '0;
  logic            in_odd = 1'b0;
  logic [4*BW-1:0] cfg_base;
  logic [4*WW-1:0] cfg_width;
  logic            out_valid;
  logic [63:0]     out_entry;
  logic [PSW-1:0]  out_ps;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  huge_tlb_splitter #(.PA_W(PA_W), .BW(BW), .WW(WW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_entry(in_entry), .in_odd(in_odd),
    .cfg_base(cfg_base), .cfg_width(cfg_width), .out_valid(out_valid),
    .out_entry(out_entry), .out_ps(out_ps)
  );

  task automatic set_slot(input int k, input int b, input int w);
    cfg_base[k*BW +: BW]  = BW'(b);
    cfg_width[k*WW +: WW] = WW'(w);
  endtask

  function automatic logic [PSW-1:0] exp_ps(input logic [63:0] e);
    logic [63:0] m;
    int k, sum;
    m = e & ((64'd1 << PA_W) - 64'd1);
    k = m[6] ? int'(m[14:13]) : 0;
    sum = int'(cfg_base[k*BW +: BW]) + int'(cfg_width[k*WW +: WW]) - 1;
    return PSW'(sum);
  endfunction

  function automatic logic [63:0] exp_entry(input logic [63:0] e, input logic odd);
    logic [63:0] m;
    int p;
    m = e & ((64'd1 << PA_W) - 64'd1);
    if (!m[6]) return m;
    p = int'(exp_ps(e));
    m[6]     = m[12];
    m[12]    = 1'b0;
    m[14:13] = 2'b00;
    if (odd && p < 64) m = m + (64'd1 << p);
    return m;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [63:0] e, input logic odd);
    @(negedge clk);
    in_entry = e; in_odd = odd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid (R1)"}, 64'(out_valid), 64'd1);
    check({tag, " entry"}, out_entry, exp_entry(e, odd));
    check({tag, " ps"}, 64'(out_ps), 64'(exp_ps(e)));
  endtask

  task automatic t_reset;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset entry", out_entry, 64'd0);
    check("R1 reset ps", 64'(out_ps), 64'd0);
  endtask

  task automatic t_plain;
    // R2 R3: upper bits dropped, odd ignored, leaf exponent
    run_one("R2 R3 plain odd", 64'hFFFF_1234_5678_9A3F & ~64'h40, 1'b1);
    check("R3 plain leaf ps", 64'(out_ps), 64'd20);
    run_one("R3 plain even", 64'h0000_0ABC_DEF0_7012, 1'b0);
  endtask

  task automatic t_huge_levels;
    // R4 R6 R7: each level picks its own slot
    run_one("R4 R6 lvl1 even", 64'h0000_0012_3400_2F5F, 1'b0);
    check("R7 lvl1 ps", 64'(out_ps), 64'd29);
    run_one("R6 lvl2 even", 64'h0000_0040_0000_4053, 1'b0);
    check("R7 lvl2 ps", 64'(out_ps), 64'd38);
    run_one("R6 lvl3 even", 64'h0000_0000_0000_6041, 1'b0);
    check("R7 lvl3 ps", 64'(out_ps), 64'd47);
    run_one("R6 lvl0 huge", 64'h0000_0000_8000_0047, 1'b0);
    check("R6 lvl0 ps", 64'(out_ps), 64'd20);
  endtask

  task automatic t_global;
    // R5: flag moved to bit 6, or bit 6 cleared when flag absent
    run_one("R5 hglb set", 64'h0000_0001_0000_3041, 1'b0);
    check("R5 g bit set", 64'(out_entry[6]), 64'd1);
    run_one("R5 hglb clear", 64'h0000_0001_0000_2041, 1'b0);
    check("R5 g bit clear", 64'(out_entry[6]), 64'd0);
  endtask

  task automatic t_odd;
    // R8: odd half offset, including carry past PA width and wide exponent
    run_one("R8 lvl1 odd", 64'h0000_0000_4000_2041, 1'b1);
    check("R8 lvl1 odd val", out_entry, 64'h0000_0000_6000_0001);
    run_one("R8 lvl3 odd carry", 64'h0000_8000_0000_6041, 1'b1);
    check("R8 carry val", out_entry, 64'h0001_0000_0000_0001);
    set_slot(3, 60, 10);
    run_one("R8 wide ps odd", 64'h0000_0000_0000_6041, 1'b1);
    check("R8 wide no add", out_entry, 64'h0000_0000_0000_0001);
    set_slot(3, 39, 9);
  endtask

  task automatic t_hold;
    logic [63:0]    e0;
    logic [PSW-1:0] p0;
    run_one("R9 load", 64'h0000_0000_1234_2041, 1'b0);
    e0 = out_entry; p0 = out_ps;
    @(negedge clk);
    in_entry = 64'hDEAD_BEEF_CAFE_6047; in_odd = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 hold entry", out_entry, e0);
    check("R9 hold ps", 64'(out_ps), 64'(p0));
    check("R1 idle valid", 64'(out_valid), 64'd0);
  endtask

  task automatic t_stream;
    logic [63:0] es [3];
    logic        os [3];
    es[0] = 64'h0000_0000_0000_2041; os[0] = 1'b1;
    es[1] = 64'h0000_0010_0000_0003; os[1] = 1'b0;
    es[2] = 64'h0000_0000_0000_5041; os[2] = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      in_entry = es[i]; in_odd = os[i]; in_valid = 1'b1;
      @(negedge clk);
      check("R10 stream valid", 64'(out_valid), 64'd1);
      check("R10 stream entry", out_entry, exp_entry(es[i], os[i]));
      check("R10 stream ps", 64'(out_ps), 64'(exp_ps(es[i])));
    end
    in_valid = 1'b0;
  endtask

  initial begin
    set_slot(0, 12, 9);
    set_slot(1, 21, 9);
    set_slot(2, 30, 9);
    set_slot(3, 39, 9);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_plain();
    t_huge_levels();
    t_global();
    t_odd();
    t_hold();
    t_stream();
    repeat (2) @(negedge clk);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule